// File: doc/BRIEF.md
# Self-Timed Word Programming Controller

This block sits behind the serial command decoder of a small word-organised non-volatile store. Once the decoder has shifted in a complete write instruction (address and a 16-bit word), it hands this block one request pulse. The block then runs a programming interval of fixed length, counted in system clock cycles. During that interval it holds its ready/busy output low and refuses new instructions. When the interval ends, it places the word into a register array. It also owns the write-enable latch, which is cleared at reset and is set or cleared by the decoder.

The write-control input `wprot` acts in two ways that depend on timing. If it is raised while a write instruction is still being shifted in, or in the request cycle itself, the write is dropped and the stored word is untouched. If it is raised during programming, the cycle stops at once. The addressed word then receives a fixed corruption pattern, and a sticky flag records the event.

After an accepted write, a falling chip select taken while the serial clock is low makes the block drive its ready/busy state onto the shared data line. Once programming has finished, chip select must go high before the next instruction is accepted.

Top module: `stw_busy_ctrl`

## Requirements
- R1: After reset, `rdy` is 1, `instr_ok` is 1, `do_oe` is 0, `aborted` is 0, every word reads 16'hFFFF and the write-enable latch is cleared.
- R2: A request only starts programming when the write-enable latch is set. A one-cycle pulse on `wen_set` sets the latch and a pulse on `wen_clr` clears it. A request made with the latch cleared leaves `rdy` high and the word unchanged.
- R3: An accepted request pulls `rdy` low in the cycle after `wr_req`. `rdy` stays low for exactly PROG_CYC cycles, and the new word reads back in the same cycle that `rdy` returns high.
- R4: While `instr_ok` is 0, `wr_req`, `wen_set` and `wen_clr` are ignored. `instr_ok` is 0 whenever `rdy` is 0.
- R5: Changes on `cs_n` during programming neither stop nor stretch the cycle.
- R6: `wprot` high while `wr_active` is 1, or in the `wr_req` cycle, cancels the write: `rdy` stays high and the word is unchanged.
- R7: `wprot` high in any programming cycle ends it. `rdy` is 1 in the next cycle, the addressed word reads CORRUPT_WORD (16'hDEAD), and `aborted` becomes 1 and stays 1 until reset.
- R8: After an accepted write, a falling `cs_n` sampled with `sclk` low sets `do_oe` in the next cycle, with `do_val` equal to `rdy`. A rising `sclk` or `cs_n` high clears `do_oe`. A `cs_n` fall with `sclk` high does not set it.
- R9: After an accepted write, `instr_ok` stays 0 until `cs_n` is seen rising while `rdy` is 1. Once that has happened, a new `cs_n` fall no longer enables `do_oe`.
- R10: A `wr_req` while `cs_n` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low active, synchronised |
| sclk | input | 1 | Serial clock level, synchronised |
| wprot | input | 1 | Write-control level, high blocks or aborts |
| wr_active | input | 1 | Write instruction being shifted in |
| wr_req | input | 1 | Write instruction complete (last data bit taken) |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Word to program |
| wen_set | input | 1 | Set the write-enable latch |
| wen_clr | input | 1 | Clear the write-enable latch |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Word stored at rd_addr |
| rdy | output | 1 | High when ready, low while programming |
| instr_ok | output | 1 | New instructions may be accepted |
| do_oe | output | 1 | Status drive enable for the data line |
| do_val | output | 1 | Status value driven on the data line |
| aborted | output | 1 | Sticky: a programming cycle was aborted |

## Verification
The bench aims at the boundaries between cancel and abort. A `wprot` pulse that comes just before the request must leave the word intact. A pulse in the first or the last busy cycle must corrupt the word. A design that confused the two would either corrupt data on a clean cancel or report a clean write after an abort. It also times the busy window to the exact cycle, because an off-by-one counter makes the word appear early or `rdy` linger. Finally it checks that a request or a latch change made while busy, or before chip select has gone high again, is really lost: a leaky gate would overwrite a second word or silently disable later writes.

// File: rtl/stw_pkg.sv
package stw_pkg;
  typedef enum logic [1:0] {
    WSRC_NONE    = 2'd0,
    WSRC_DATA    = 2'd1,
    WSRC_CORRUPT = 2'd2
  } wsrc_e;
endpackage

// File: rtl/stw_level_hist.sv
module stw_level_hist #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= d;
  end
endmodule

// File: rtl/stw_timer.sv
module stw_timer #(
  parameter int unsigned CYC = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign done = busy_q & (cnt_q == '0) & ~abort;
  assign busy = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CW'(CYC - 1);
    end else if (abort || done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  // R3: the interval counts down one per cycle without ending early
  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0 && !abort) |=> (busy_q && cnt_q == $past(cnt_q) - CW'(1)));
  // R4: no restart is requested while a cycle runs
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !start);
endmodule

// File: rtl/stw_store.sv
module stw_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/stw_busy_ctrl.sv
module stw_busy_ctrl
  import stw_pkg::*;
#(
  parameter int unsigned   AW           = 8,
  parameter int unsigned   DW           = 16,
  parameter int unsigned   PROG_CYC     = 2500000,
  parameter logic [DW-1:0] CORRUPT_WORD = DW'(16'hDEAD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          wprot,
  input  logic          wr_active,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wen_set,
  input  logic          wen_clr,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rdy,
  output logic          instr_ok,
  output logic          do_oe,
  output logic          do_val,
  output logic          aborted
);
  logic          cs_prev, sclk_prev;
  logic          cs_rise, cs_fall, sclk_rise;
  logic          busy, done, abort, start;
  logic          wel_q, wel_d;
  logic          cancel_q, cancel_d;
  logic          pend_q, pend_d;
  logic          stat_q, stat_d;
  logic          abt_q, abt_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  wsrc_e         wsrc;
  logic          st_we;
  logic [DW-1:0] st_wdata;

  stw_level_hist #(.RST_VAL(1'b1)) u_cs_hist (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_prev));
  stw_level_hist #(.RST_VAL(1'b0)) u_sclk_hist (
    .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_prev));

  assign cs_rise   = ~cs_prev & cs_n;
  assign cs_fall   = cs_prev & ~cs_n;
  assign sclk_rise = ~sclk_prev & sclk;

  assign instr_ok = ~busy & ~pend_q;
  assign start    = wr_req & ~cs_n & instr_ok & wel_q & ~wprot & ~cancel_q;
  assign abort    = busy & wprot;

  stw_timer #(.CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .busy(busy), .done(done));

  // next-state logic for control flags
  always_comb begin
    wel_d = wel_q;
    if (instr_ok) begin
      if (wen_clr)      wel_d = 1'b0;
      else if (wen_set) wel_d = 1'b1;
    end

    cancel_d = cancel_q;
    if (cs_n)                     cancel_d = 1'b0;
    else if (wr_active && wprot)  cancel_d = 1'b1;
    else if (wr_req)              cancel_d = 1'b0;

    pend_d = pend_q;
    if (start)                pend_d = 1'b1;
    else if (cs_rise && !busy) pend_d = 1'b0;

    stat_d = stat_q;
    if (cs_n || sclk_rise)               stat_d = 1'b0;
    else if (cs_fall && !sclk && pend_q) stat_d = 1'b1;

    abt_d = abt_q | abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q    <= 1'b0;
      cancel_q <= 1'b0;
      pend_q   <= 1'b0;
      stat_q   <= 1'b0;
      abt_q    <= 1'b0;
    end else begin
      wel_q    <= wel_d;
      cancel_q <= cancel_d;
      pend_q   <= pend_d;
      stat_q   <= stat_d;
      abt_q    <= abt_d;
    end
  end

  // request capture, enabled only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  always_comb begin
    if (abort)     wsrc = WSRC_CORRUPT;
    else if (done) wsrc = WSRC_DATA;
    else           wsrc = WSRC_NONE;
    st_we    = (wsrc != WSRC_NONE);
    st_wdata = (wsrc == WSRC_CORRUPT) ? CORRUPT_WORD : data_q;
  end

  stw_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(st_we), .waddr(addr_q), .wdata(st_wdata),
    .raddr(rd_addr), .rdata(rd_data));

  assign rdy     = ~busy;
  assign do_oe   = stat_q;
  assign do_val  = stat_q & ~busy;
  assign aborted = abt_q;

  // R3: accepted request shows busy next cycle
  a_r3_rdy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rdy);
  // R7: write-control during programming frees the block and flags it
  a_r7_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wprot) |=> (rdy && aborted));
  // R7: abort flag is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |=> aborted);
  // R8: status drive only follows a select fall with serial clock low after a write
  a_r8_status_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe) |-> ($past(pend_q) && !$past(sclk)));
  // R9: gate stays closed while a write is pending
  a_r9_gate_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cs_rise) |=> !instr_ok);
endmodule

// File: tb/sim_stw_busy_ctrl.sv
module sim_stw_busy_ctrl;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int PC = 24;
  localparam logic [15:0] CORR = 16'hDEAD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, wprot = 1'b0, wr_active = 1'b0, wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic wen_set = 1'b0, wen_clr = 1'b0;
  logic [DW-1:0] rd_data;
  logic rdy, instr_ok, do_oe, do_val, aborted;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] mdl [256];
  bit wel_m = 0;
  bit ab_m = 0;

  always #2 clk = ~clk;

  stw_busy_ctrl #(.AW(AW), .DW(DW), .PROG_CYC(PC), .CORRUPT_WORD(CORR)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .wprot(wprot),
    .wr_active(wr_active), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wen_set(wen_set), .wen_clr(wen_clr), .rd_addr(rd_addr), .rd_data(rd_data),
    .rdy(rdy), .instr_ok(instr_ok), .do_oe(do_oe), .do_val(do_val), .aborted(aborted));

  function automatic logic [15:0] exp_word(logic [15:0] old, logic [15:0] nw,
                                           bit commit, bit abrt);
    if (!commit) return old;
    if (abrt) return CORR;
    return nw;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_word(string req, logic [AW-1:0] a);
    rd_addr = a;
    #0;
    chk(req, 32'(rd_data), 32'(mdl[a]));
  endtask

  task automatic wen(bit set);
    @(negedge clk);
    cs_n = 1'b0;
    if (set) wen_set = 1'b1; else wen_clr = 1'b1;
    @(negedge clk);
    wen_set = 1'b0; wen_clr = 1'b0;
    if (instr_ok) wel_m = set;
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  // abort_j < 0: no abort; otherwise raise wprot in busy state k == abort_j
  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, bit cancel, int abort_j);
    bit commit;
    @(negedge clk);
    cs_n = 1'b0; sclk = 1'b0; wr_active = 1'b1;
    if (cancel) wprot = 1'b1;
    @(negedge clk);
    wprot = 1'b0;
    @(negedge clk);
    wr_active = 1'b0; wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    commit = wel_m && !cancel;
    if (!commit) begin
      chk(cancel ? "R6 rdy stays high" : "R2 rdy stays high", 32'(rdy), 32'd1);
      chk_word(cancel ? "R6 word kept" : "R2 word kept", a);
    end else begin
      for (int k = 0; k <= PC; k++) begin
        if (abort_j == k) begin
          wprot = 1'b1;
          @(negedge clk);
          wprot = 1'b0;
          mdl[a] = exp_word(mdl[a], d, 1, 1);
          ab_m = 1;
          chk("R7 rdy after abort", 32'(rdy), 32'd1);
          chk("R7 aborted flag", 32'(aborted), 32'd1);
          chk_word("R7 corrupt word", a);
          break;
        end
        if (k < PC) begin
          chk("R3 busy window", 32'(rdy), 32'd0);
          if (k == 0) chk("R4 gate closed", 32'(instr_ok), 32'd0);
          @(negedge clk);
        end else begin
          mdl[a] = exp_word(mdl[a], d, 1, 0);
          chk("R3 rdy back high", 32'(rdy), 32'd1);
          chk_word("R3 word written", a);
          chk("R9 gate held before cs high", 32'(instr_ok), 32'd0);
        end
      end
    end
    cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 gate open after cs high", 32'(instr_ok), 32'd1);
    chk("R7 sticky flag", 32'(aborted), 32'(ab_m));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mdl[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdy", 32'(rdy), 32'd1);
    chk("R1 instr_ok", 32'(instr_ok), 32'd1);
    chk("R1 do_oe", 32'(do_oe), 32'd0);
    chk("R1 aborted", 32'(aborted), 32'd0);
    chk_word("R1 erased word", 8'h00);
    chk_word("R1 erased word", 8'hFF);
    // R1/R2: latch cleared at reset, write refused
    do_write(8'h10, 16'h1234, 0, -1);

    wen(1);
    do_write(8'h10, 16'h1234, 0, -1);   // R3 normal
    do_write(8'h11, 16'h5678, 1, -1);   // R6 cancel
    do_write(8'h12, 16'h9ABC, 0, 0);    // R7 abort first busy cycle
    do_write(8'h13, 16'h0F0F, 0, PC-1); // R7 abort last busy cycle

    // R10: request with cs_n high ignored
    @(negedge clk);
    cs_n = 1'b1; wr_req = 1'b1; wr_addr = 8'h20; wr_data = 16'h0000;
    @(negedge clk);
    wr_req = 1'b0;
    chk("R10 rdy high", 32'(rdy), 32'd1);
    chk_word("R10 word kept", 8'h20);

    // R6: wprot high in the request cycle
    @(negedge clk);
    cs_n = 1'b0; wprot = 1'b1; wr_req = 1'b1; wr_addr = 8'h21; wr_data = 16'h0;
    @(negedge clk);
    wr_req = 1'b0; wprot = 1'b0;
    chk("R6 req-cycle cancel rdy", 32'(rdy), 32'd1);
    chk_word("R6 req-cycle word", 8'h21);
    cs_n = 1'b1;

    // R4/R5/R8: start a write, then poke during busy
    @(negedge clk);
    cs_n = 1'b0; sclk = 1'b0; wr_req = 1'b1; wr_addr = 8'h30; wr_data = 16'hC0DE;
    @(negedge clk);
    wr_req = 1'b1; wr_addr = 8'h31; wr_data = 16'h1111; wen_clr = 1'b1;
    @(negedge clk);
    wr_req = 1'b0; wen_clr = 1'b0;
    cs_n = 1'b1; sclk = 1'b1;          // R5 cs toggles during busy
    @(negedge clk);
    cs_n = 1'b0;                       // fall with sclk high: no status (R8)
    @(negedge clk);
    chk("R8 no status sclk high", 32'(do_oe), 32'd0);
    cs_n = 1'b1; sclk = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R8 status enabled", 32'(do_oe), 32'd1);
    chk("R8 status busy", 32'(do_val), 32'd0);
    chk("R5 still busy", 32'(rdy), 32'd0);
    repeat (PC) @(negedge clk);
    mdl[8'h30] = 16'hC0DE;
    chk("R5 completes", 32'(rdy), 32'd1);
    chk("R8 status ready", 32'(do_val), 32'd1);
    chk_word("R3 word 30", 8'h30);
    chk_word("R4 second request lost", 8'h31);
    sclk = 1'b1;
    @(negedge clk);
    chk("R8 sclk rise drops drive", 32'(do_oe), 32'd0);
    sclk = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b0;
    @(negedge clk);
    chk("R9 no status after release", 32'(do_oe), 32'd0);
    chk("R9 gate open", 32'(instr_ok), 32'd1);
    cs_n = 1'b1;
    // R4: wen_clr during busy was lost, so latch still set
    do_write(8'h32, 16'h2222, 0, -1);

    // constrained random mix
    for (int n = 0; n < 120; n++) begin
      int mode;
      mode = int'($urandom % 8);
      a = AW'($urandom);
      d = DW'($urandom);
      case (mode)
        0: wen(($urandom % 4) != 0);
        1: do_write(a, d, 1, -1);
        2: do_write(a, d, 0, int'($urandom % PC));
        default: do_write(a, d, 0, -1);
      endcase
    end
    for (int i = 0; i < 256; i += 17) chk_word("R3 final contents", AW'(i));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule